// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a bank of external interrupt pins, from one up to thirty-two, and turns activity on each pin into an interrupt request toward a CPU. Every pin first passes through a two-stage synchroniser. Software then picks, for each line on its own, what counts as an event: a held low level, a held high level, a falling edge, a rising edge, or either edge. All of these are judged in the clock domain of the block.

A detected event sets a sticky bit in the detect register. Software clears that bit by writing a one to it. A separate enable mask decides which detect bits reach the CPU. The mask has its own set address and its own clear address, so software can mask or unmask one line with a single write and no read-modify-write. The CPU-facing view is the detect bits ANDed with the enable mask. That view drives one registered interrupt output per line.

The register port is a plain single-cycle bus. A write takes effect on the clock edge where the write strobe is high. Read data is registered: it reflects the address presented in the cycle before.

Top module: `extint_ctrl`

## Requirements
- R1: The monitor register at byte offset 0x104 returns the synchronised level of every pin, with bit n for pin n and zeros above the line count. Read data for any address appears on the clock edge that follows the cycle in which the address is presented.
- R2: Line n has a configuration word at byte offset 0x180 + 4*n. Its low six bits are stored and read back, and its higher bits read as zero. A configuration address at or beyond the line count reads as zero.
- R3: Sense code 0x01 detects a low level and code 0x02 detects a high level. While the level holds, the detect bit stays set, and a clear attempt leaves it set because detection is re-evaluated every cycle.
- R4: Sense code 0x04 detects a falling edge, 0x08 a rising edge and 0x0C either edge. An edge is a change of the synchronised level between consecutive cycles. A level that is held without change sets nothing.
- R5: Any sense code other than 0x01, 0x02, 0x04, 0x08 and 0x0C detects nothing on that line.
- R6: The detect register at 0x100 holds one sticky bit per line. Writing 1 to a bit clears it, and writing 0 leaves it alone. If a detection and a clear of the same bit land on the same clock edge, the bit ends up set.
- R7: Writing 1 to bit n at 0x08 enables line n, and writing 1 to bit n at 0x04 disables it. Zero bits in either write leave the mask unchanged. Reading 0x04 returns the enable mask, and reading 0x08 returns zero.
- R8: The request register at 0x00 reads as detect AND enable. Output irq_o[n] is request bit n registered. An edge on a pin that is driven just before clock edge k raises irq_o on edge k+3.
- R9: Reset clears every configuration word, every enable bit, every detect bit and every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_LINES | Asynchronous external interrupt pins |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte address; only word-aligned addresses hit a register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| irq_o | output | NUM_LINES | Per-line interrupt requests toward the CPU |

## Verification
The bench works on a four-line instance. It sweeps every line through all five valid sense codes and three invalid ones, starting from each of the four pairs of old and new pin levels, and compares the detect, request and output values against a model in the bench. It also goes after the same-edge race between a detection and a write-one clear. A design that let the clear win would lose an edge that arrived while software was acknowledging the previous one. In level mode, a design that failed to re-set the bit after a clear would lose a level that is still being held. The bench checks zero bits in clear and enable writes, because a design that wrote the whole word would clear or mask other lines. It measures the pin-to-output latency cycle by cycle, so an extra or missing synchroniser stage is caught, and it checks that an unmasked line drops its output as soon as it is disabled.

// File: rtl/extint_pkg.sv
package extint_pkg;

  localparam int unsigned CFG_W     = 6;
  localparam int unsigned CFG_IDX_W = 5;

  typedef enum logic [CFG_W-1:0] {
    SENSE_OFF  = 6'h00,
    SENSE_LOW  = 6'h01,
    SENSE_HIGH = 6'h02,
    SENSE_FALL = 6'h04,
    SENSE_RISE = 6'h08,
    SENSE_BOTH = 6'h0C
  } sense_e;

  localparam logic [8:0] OFS_REQ      = 9'h000;
  localparam logic [8:0] OFS_EN_CLR   = 9'h004;
  localparam logic [8:0] OFS_EN_SET   = 9'h008;
  localparam logic [8:0] OFS_DET      = 9'h100;
  localparam logic [8:0] OFS_MON      = 9'h104;
  localparam logic [8:0] OFS_CFG_BASE = 9'h180;

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] lvl_prev_o
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  assign lvl_o      = stage_q[STAGES-1];
  assign lvl_prev_o = prev_q;

  AST_PREV_TRACKS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (lvl_prev_o == $past(lvl_o))); // R4

endmodule

// File: rtl/extint_line.sv
module extint_line
  import extint_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl_i,
  input  logic             lvl_prev_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             clr_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             det_o
);

  logic [CFG_W-1:0] cfg_q;
  logic             det_q;
  logic             hit;
  logic             sense_valid;

  always_ff @(posedge clk) begin
    if (rst)           cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_wdata_i;
  end

  always_comb begin
    hit         = 1'b0;
    sense_valid = 1'b1;
    case (cfg_q)
      SENSE_LOW:  hit = ~lvl_i;
      SENSE_HIGH: hit = lvl_i;
      SENSE_FALL: hit = ~lvl_i & lvl_prev_i;
      SENSE_RISE: hit = lvl_i & ~lvl_prev_i;
      SENSE_BOTH: hit = lvl_i ^ lvl_prev_i;
      default:    sense_valid = 1'b0;
    endcase
  end

  // detection outranks a simultaneous write-one clear
  always_ff @(posedge clk) begin
    if (rst)        det_q <= 1'b0;
    else if (hit)   det_q <= 1'b1;
    else if (clr_i) det_q <= 1'b0;
  end

  assign cfg_o = cfg_q;
  assign det_o = det_q;

  AST_HIT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (hit && clr_i) |=> det_o); // R6
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !hit) |=> !det_o); // R6
  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (cfg_q == SENSE_HIGH && lvl_i && !cfg_we_i) |=> det_o); // R3
  AST_NO_SENSE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!sense_valid && !det_o) |=> !det_o); // R5

endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 32,
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] pin_i,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [NUM_LINES-1:0] irq_o
);

  localparam int unsigned CFG_END = 32'h180 + 4 * NUM_LINES;

  logic [NUM_LINES-1:0] lvl, lvl_prev;
  logic [NUM_LINES-1:0] det_vec;
  logic [NUM_LINES-1:0] en_q;
  logic [NUM_LINES-1:0] irq_q;
  logic [NUM_LINES-1:0] set_mask, clr_mask, det_clr;
  logic [CFG_W-1:0]     cfg_arr [NUM_LINES];
  logic [DATA_W-1:0]    rd_nxt, rdata_q;
  logic [CFG_IDX_W-1:0] cfg_idx;
  logic hit_req, hit_en_clr, hit_en_set, hit_det, hit_mon, hit_cfg;

  extint_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .async_i    (pin_i),
    .lvl_o      (lvl),
    .lvl_prev_o (lvl_prev)
  );

  // address decode (full byte address, so misaligned accesses hit nothing)
  assign hit_req    = (bus_addr == ADDR_W'(OFS_REQ));
  assign hit_en_clr = (bus_addr == ADDR_W'(OFS_EN_CLR));
  assign hit_en_set = (bus_addr == ADDR_W'(OFS_EN_SET));
  assign hit_det    = (bus_addr == ADDR_W'(OFS_DET));
  assign hit_mon    = (bus_addr == ADDR_W'(OFS_MON));
  assign hit_cfg    = (bus_addr >= ADDR_W'(OFS_CFG_BASE))
                   && ({1'b0, bus_addr} < (ADDR_W+1)'(CFG_END))
                   && (bus_addr[1:0] == 2'b00);
  assign cfg_idx    = bus_addr[CFG_IDX_W+1:2];

  assign set_mask = (bus_we && hit_en_set) ? bus_wdata[NUM_LINES-1:0] : '0;
  assign clr_mask = (bus_we && hit_en_clr) ? bus_wdata[NUM_LINES-1:0] : '0;
  assign det_clr  = (bus_we && hit_det)    ? bus_wdata[NUM_LINES-1:0] : '0;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    extint_line u_line (
      .clk         (clk),
      .rst         (rst),
      .lvl_i       (lvl[g]),
      .lvl_prev_i  (lvl_prev[g]),
      .cfg_we_i    (bus_we && hit_cfg && (cfg_idx == CFG_IDX_W'(g))),
      .cfg_wdata_i (bus_wdata[CFG_W-1:0]),
      .clr_i       (det_clr[g]),
      .cfg_o       (cfg_arr[g]),
      .det_o       (det_vec[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      irq_q <= '0;
    end else begin
      en_q  <= (en_q | set_mask) & ~clr_mask;
      irq_q <= det_vec & en_q;
    end
  end

  always_comb begin
    rd_nxt = '0;
    if (hit_req)    rd_nxt = DATA_W'(det_vec & en_q);
    if (hit_en_clr) rd_nxt = DATA_W'(en_q);
    if (hit_det)    rd_nxt = DATA_W'(det_vec);
    if (hit_mon)    rd_nxt = DATA_W'(lvl);
    if (hit_cfg) begin
      for (int i = 0; i < NUM_LINES; i++)
        if (cfg_idx == CFG_IDX_W'(i)) rd_nxt = DATA_W'(cfg_arr[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_nxt;
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irq_o & ~$past(en_q)) == '0)); // R8
  AST_EN_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
    (bus_we && hit_en_set) |=> ((en_q & $past(set_mask)) == $past(set_mask))); // R7
  AST_EN_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (bus_we && hit_en_clr) |=> ((en_q & $past(clr_mask)) == '0)); // R7
  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (irq_o == '0 && en_q == '0 && det_vec == '0)); // R9

endmodule

// File: tb/extint_ctrl_tb.sv
module extint_ctrl_tb;

  localparam int N = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  pin = '0;
  logic          we = 1'b0;
  logic [8:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  extint_ctrl #(.NUM_LINES(N), .ADDR_W(9), .DATA_W(32), .SYNC_STAGES(2)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .pin_i     (pin),
    .bus_we    (we),
    .bus_addr  (addr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .irq_o     (irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [8:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  function automatic bit lvl_hit(input logic [5:0] code, input bit v);
    if (code == 6'h01) return !v;
    if (code == 6'h02) return v;
    return 1'b0;
  endfunction

  function automatic bit edge_hit(input logic [5:0] code, input bit a, input bit b);
    if (code == 6'h04) return a && !b;
    if (code == 6'h08) return !a && b;
    if (code == 6'h0C) return a != b;
    return 1'b0;
  endfunction

  function automatic logic [8:0] cfg_addr(input int n);
    return 9'(9'h180 + 4 * n);
  endfunction

  function automatic string req_of(input logic [5:0] code);
    if (code == 6'h01 || code == 6'h02) return "R3";
    if (code == 6'h04 || code == 6'h08 || code == 6'h0C) return "R4";
    return "R5";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] codes [8];
    codes[0] = 6'h01; codes[1] = 6'h02; codes[2] = 6'h04; codes[3] = 6'h08;
    codes[4] = 6'h0C; codes[5] = 6'h00; codes[6] = 6'h03; codes[7] = 6'h3F;

    wait_n(4);
    rst = 1'b0;
    wait_n(1);

    // R9 reset state
    chk("R9 irq after reset", 32'(irq), 32'h0);
    rd_chk("R9 request", 9'h000, 32'h0);
    rd_chk("R9 enable", 9'h004, 32'h0);
    rd_chk("R9 detect", 9'h100, 32'h0);
    for (int n = 0; n < N; n++) rd_chk("R9 config", cfg_addr(n), 32'h0);

    // R2 config readback, upper bits dropped, out-of-range index
    for (int n = 0; n < N; n++) wr(cfg_addr(n), 32'hFFFF_FFC0 | 32'(n + 1));
    for (int n = 0; n < N; n++) rd_chk("R2 config readback", cfg_addr(n), 32'(n + 1));
    wr(cfg_addr(N), 32'h3F);
    rd_chk("R2 out of range config", cfg_addr(N), 32'h0);
    for (int n = 0; n < N; n++) wr(cfg_addr(n), 32'h0);
    wr(9'h100, 32'hF);

    // R1 monitor sweep
    for (int p = 0; p < 16; p++) begin
      pin = 4'(p);
      wait_n(3);
      rd_chk("R1 monitor", 9'h104, 32'(p));
    end
    pin = '0;
    wait_n(4);

    // R7 set-address reads zero, zero bits leave mask alone
    wr(9'h008, 32'h5);
    rd_chk("R7 enable mask", 9'h004, 32'h5);
    rd_chk("R7 set reads zero", 9'h008, 32'h0);
    wr(9'h008, 32'h0);
    wr(9'h004, 32'h0);
    rd_chk("R7 zero writes no effect", 9'h004, 32'h5);
    wr(9'h004, 32'h1);
    rd_chk("R7 clear one bit", 9'h004, 32'h4);
    wr(9'h004, 32'hF);

    // R3 R4 R5 R7 R8 sweep
    for (int l = 0; l < N; l++) begin
      for (int c = 0; c < 8; c++) begin
        for (int ab = 0; ab < 4; ab++) begin
          bit a = ab[1];
          bit b = ab[0];
          bit e0, e1;
          logic [5:0] code = codes[c];
          e0 = lvl_hit(code, a);
          e1 = lvl_hit(code, a) || lvl_hit(code, b) || edge_hit(code, a, b);
          wr(cfg_addr(l), 32'h0);
          pin[l] = a;
          wait_n(4);
          wr(9'h100, 32'hF);
          wr(cfg_addr(l), 32'(code));
          wait_n(4);
          wr(9'h100, 32'(1) << l);
          wait_n(2);
          rd_chk({req_of(code), " detect after clear"}, 9'h100, 32'(e0) << l);
          pin[l] = b;
          wait_n(5);
          rd_chk({req_of(code), " detect after change"}, 9'h100, 32'(e1) << l);
          wr(9'h008, 32'(1) << l);
          wait_n(2);
          chk("R8 irq enabled", 32'(irq), 32'(e1) << l);
          rd_chk("R8 request view", 9'h000, 32'(e1) << l);
          wr(9'h004, 32'(1) << l);
          wait_n(2);
          chk("R8 irq disabled", 32'(irq), 32'h0);
          rd_chk("R7 mask cleared", 9'h004, 32'h0);
          rd_chk("R6 detect kept when masked", 9'h100, 32'(e1) << l);
          wr(cfg_addr(l), 32'h0);
          wr(9'h100, 32'hF);
        end
      end
      pin[l] = 1'b0;
      wait_n(4);
    end

    // R6 zero bits and other bits do not clear
    wr(cfg_addr(2), 32'h0C);
    wait_n(2);
    wr(9'h100, 32'hF);
    pin[2] = 1'b1;
    wait_n(5);
    wr(9'h100, 32'h0);
    wr(9'h100, 32'hB);
    rd_chk("R6 zero write keeps bit", 9'h100, 32'h4);
    wr(9'h100, 32'h4);
    rd_chk("R6 one write clears", 9'h100, 32'h0);
    wr(cfg_addr(2), 32'h0);
    pin[2] = 1'b0;
    wait_n(4);

    // R6 detection wins over a clear on the same edge
    wr(cfg_addr(0), 32'h08);
    wr(9'h100, 32'hF);
    pin[0] = 1'b1;
    wait_n(5);
    rd_chk("R6 setup detect", 9'h100, 32'h1);
    pin[0] = 1'b0;
    wait_n(4);
    pin[0] = 1'b1;
    wait_n(2);
    wr(9'h100, 32'h1);
    rd_chk("R6 detect beats clear", 9'h100, 32'h1);
    wr(9'h100, 32'h1);
    rd_chk("R6 later clear takes", 9'h100, 32'h0);
    wr(cfg_addr(0), 32'h0);
    pin[0] = 1'b0;
    wait_n(4);

    // R8 latency from pin to irq
    wr(cfg_addr(1), 32'h08);
    wr(9'h008, 32'h2);
    wr(9'h100, 32'hF);
    wait_n(2);
    pin[1] = 1'b1;
    wait_n(3);
    chk("R8 irq not yet", 32'(irq), 32'h0);
    wait_n(1);
    chk("R8 irq on third edge", 32'(irq), 32'h2);

    // R9 reset mid-run clears state
    wr(cfg_addr(3), 32'h02);
    wr(9'h008, 32'hF);
    rst = 1'b1;
    wait_n(2);
    rst = 1'b0;
    pin = '0;
    wait_n(1);
    chk("R9 irq after reset", 32'(irq), 32'h0);
    rd_chk("R9 enable cleared", 9'h004, 32'h0);
    rd_chk("R9 config cleared", cfg_addr(3), 32'h0);
    rd_chk("R9 config1 cleared", cfg_addr(1), 32'h0);
    wait_n(4);
    rd_chk("R9 detect cleared", 9'h100, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule